// File: doc/BRIEF.md
# Sixteen-bit multiply-accumulate unit

This block is the multiply-accumulate datapath of a small processor core. Each request multiplies one 16-bit half of a first 32-bit operand by one 16-bit half of a second. The product either overwrites a 40-bit accumulator or is added to it or subtracted from it. The accumulator is held as a 32-bit low word and a 32-bit upper word. Only the bottom 8 bits of the upper word are significant, and the upper word is always kept sign-extended from its bit 7.

Each operand comes either from a general-register data input or from one of four internal multiplier registers. A request may also carry an operand load. The block forms an address from the base input plus or minus 4 and reads one aligned word through a simple read port. It writes that word into a chosen multiplier register and hands the updated address back as the new base. A load can run on its own or together with a multiply-add. Illegal combinations and misaligned load addresses are flagged, and they change no state.

The accumulator can also be written directly, one word at a time. Completion is signalled by a one-cycle `done` pulse.

Top module: `halfmac_unit`

## Requirements
- R1: Operand half selection: a half-select bit of 1 takes bits [31:16] of the operand word and 0 takes bits [15:0]. The chosen half is zero-extended for the unsigned-multiply class and sign-extended for every other class.
- R2: `req_class` encoding is 0 = unsigned multiply, 1 = signed multiply, 2 = multiply-add, 3 = multiply-subtract. Unsigned multiply writes the 32-bit product to the low word and clears the upper word.
- R3: Signed multiply writes the 32-bit product to the low word and fills all 32 bits of the upper word with product bit 31.
- R4: Multiply-add and multiply-subtract add the sign-extended product to, or subtract it from, the 40-bit value {upper[7:0], low}. They store the low 32 bits, and store the upper word sign-extended from result bit 39. `acc_hi[31:8]` always equals 24 copies of `acc_hi[7]`.
- R5: With `req_src_a_m` = 1 the first operand is multiplier register 0 (`req_sel_x` = 0) or 1 (`req_sel_x` = 1). With `req_src_b_m` = 1 the second operand is register 2 (`req_sel_y` = 0) or 3 (`req_sel_y` = 1). Otherwise each operand comes from `rs_data` or `rt_data`.
- R6: A load (`req_load` = 1) reads address `rs_data`+4, or `rs_data`-4 when `req_dec` = 1. The returned word goes to multiplier register `req_ld_dst`. `base_wr_en` pulses with `base_wr_data` equal to that address. When a load is combined with a multiply, the first operand always comes from a multiplier register, and the multiply uses the register contents from before the load.
- R7: A load-only request (`req_mul` = 0, `req_load` = 1) leaves the accumulator unchanged.
- R8: `reserved_err` pulses with `done`, and nothing else happens (no accumulator, register or base update, no memory read), in three cases: a load combined with any class other than multiply-add; unsigned multiply with any operand taken from a multiplier register; a request with neither multiply nor load.
- R9: A non-reserved load whose address has bits [1:0] not equal to 0 pulses `align_err` with `done`. It issues no read and updates no state.
- R10: A direct write (`acc_wr_en`) stores `acc_wr_data` into the low word (`acc_wr_hi` = 0), or stores it sign-extended from bit 7 into the upper word (`acc_wr_hi` = 1). It is ignored in any cycle in which a request is accepted or a load is outstanding.
- R11: A request is accepted on a clock edge with `req_valid` and `req_ready` high. Without a load, `done` is high in the following cycle. With a load, `mem_rd_req` holds with a stable address and `req_ready` stays low until `mem_rd_valid` is seen, and `done` is high in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_class | input | 2 | Operation class (R2 encoding) |
| req_src_a_m | input | 1 | First operand from multiplier register |
| req_src_b_m | input | 1 | Second operand from multiplier register |
| req_hi_a | input | 1 | Upper half of first operand |
| req_hi_b | input | 1 | Upper half of second operand |
| req_sel_x | input | 1 | First multiplier register select (0 or 1) |
| req_sel_y | input | 1 | Second multiplier register select (2 or 3) |
| req_mul | input | 1 | Perform a multiply |
| req_load | input | 1 | Perform an operand load |
| req_dec | input | 1 | Load address is base minus 4 |
| req_ld_dst | input | 2 | Multiplier register receiving the load |
| rs_data | input | 32 | First register word / load base |
| rt_data | input | 32 | Second register word |
| mem_rd_req | output | 1 | Read request, held until answered |
| mem_rd_addr | output | 32 | Read word address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Read data |
| acc_wr_en | input | 1 | Direct accumulator write |
| acc_wr_hi | input | 1 | Direct write targets the upper word |
| acc_wr_data | input | 32 | Direct write data |
| acc_lo | output | 32 | Accumulator low word |
| acc_hi | output | 32 | Accumulator upper word |
| base_wr_en | output | 1 | Updated base valid |
| base_wr_data | output | 32 | Updated base address |
| done | output | 1 | Request complete |
| reserved_err | output | 1 | Illegal request combination |
| align_err | output | 1 | Misaligned load address |

## Verification
A wrong multiplier register is invisible until a later multiply reads it. So every load is followed by multiplies that select the loaded register in both halves and with both selector values, and the accumulator shows the result one cycle after the request. An accumulator upper word that has lost its sign extension shows up at once on `acc_hi`. It is also exposed by a multiply-add that carries across bit 31 and by a following multiply-subtract that must return to the earlier value. A faulty decode of the illegal combinations shows up in the `done` cycle: the error flag is missing, a read request appears, or the accumulator changes.

// File: rtl/halfmac_pkg.sv
package halfmac_pkg;
    localparam int WORD_W     = 32;
    localparam int HALF_W     = 16;
    localparam int TOP_W      = 8;
    localparam int ACC_W      = WORD_W + TOP_W;
    localparam int NUM_MREG   = 4;
    localparam int MREG_IDX_W = $clog2(NUM_MREG);
    localparam int ADDR_STEP  = 4;
    localparam int ALIGN_W    = $clog2(ADDR_STEP);

    typedef enum logic [1:0] {
        CLS_UMUL = 2'd0,
        CLS_MUL  = 2'd1,
        CLS_MULA = 2'd2,
        CLS_MULS = 2'd3
    } mac_class_e;

    typedef enum logic { ST_IDLE, ST_WAIT } mac_state_e;

    typedef struct packed {
        mac_class_e            cls;
        logic                  src_a_m;
        logic                  src_b_m;
        logic                  hi_a;
        logic                  hi_b;
        logic                  sel_x;
        logic                  sel_y;
        logic                  do_mul;
        logic                  do_load;
        logic                  dec;
        logic [MREG_IDX_W-1:0] ld_dst;
    } mac_req_t;

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
    } acc_t;

    // Extract one half of a word and widen it to a full word.
    function automatic logic [WORD_W-1:0] half_pick(
        input logic [WORD_W-1:0] w,
        input logic              upper,
        input logic              uns
    );
        logic [HALF_W-1:0] h;
        h = upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
        return {{(WORD_W-HALF_W){~uns & h[HALF_W-1]}}, h};
    endfunction

    // Widen the significant top byte of the accumulator to a word.
    function automatic logic [WORD_W-1:0] top_sext(input logic [TOP_W-1:0] b);
        return {{(WORD_W-TOP_W){b[TOP_W-1]}}, b};
    endfunction
endpackage

// File: rtl/halfmac_operand.sv
module halfmac_operand
    import halfmac_pkg::*;
(
    input  logic [WORD_W-1:0] reg_word,
    input  logic [WORD_W-1:0] m_first,
    input  logic [WORD_W-1:0] m_second,
    input  logic              from_mreg,
    input  logic              pick_second,
    input  logic              take_upper,
    input  logic              is_unsigned,
    output logic [WORD_W-1:0] value
);
    logic [WORD_W-1:0] src_word;

    always_comb begin
        if (from_mreg) src_word = pick_second ? m_second : m_first;
        else           src_word = reg_word;
        value = half_pick(src_word, take_upper, is_unsigned);
    end
endmodule

// File: rtl/halfmac_mregs.sv
module halfmac_mregs
    import halfmac_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_en,
    input  logic [MREG_IDX_W-1:0]              wr_idx,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic [NUM_MREG-1:0][WORD_W-1:0]    regs
);
    for (genvar gi = 0; gi < NUM_MREG; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[gi] <= '0;
            else if (wr_en && wr_idx == MREG_IDX_W'(gi))
                regs[gi] <= wr_data;
        end
    end
endmodule

// File: rtl/halfmac_accum.sv
module halfmac_accum
    import halfmac_pkg::*;
(
    input  mac_class_e        cls,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [WORD_W-1:0] lo_in,
    input  logic [TOP_W-1:0]  top_in,
    output logic [WORD_W-1:0] lo_out,
    output logic [WORD_W-1:0] hi_out
);
    logic [WORD_W-1:0] prod;
    logic [ACC_W-1:0]  acc_cur;
    logic [ACC_W-1:0]  prod_wide;
    logic [ACC_W-1:0]  acc_res;

    always_comb begin
        prod      = op_a * op_b;
        acc_cur   = {top_in, lo_in};
        prod_wide = {{TOP_W{prod[WORD_W-1]}}, prod};
        acc_res   = (cls == CLS_MULS) ? acc_cur - prod_wide : acc_cur + prod_wide;
        unique case (cls)
            CLS_UMUL: begin lo_out = prod; hi_out = '0; end
            CLS_MUL:  begin lo_out = prod; hi_out = {WORD_W{prod[WORD_W-1]}}; end
            default:  begin
                lo_out = acc_res[WORD_W-1:0];
                hi_out = top_sext(acc_res[ACC_W-1:WORD_W]);
            end
        endcase
    end
endmodule

// File: rtl/halfmac_unit.sv
module halfmac_unit
    import halfmac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_class,
    input  logic                  req_src_a_m,
    input  logic                  req_src_b_m,
    input  logic                  req_hi_a,
    input  logic                  req_hi_b,
    input  logic                  req_sel_x,
    input  logic                  req_sel_y,
    input  logic                  req_mul,
    input  logic                  req_load,
    input  logic                  req_dec,
    input  logic [MREG_IDX_W-1:0] req_ld_dst,
    input  logic [WORD_W-1:0]     rs_data,
    input  logic [WORD_W-1:0]     rt_data,
    output logic                  mem_rd_req,
    output logic [WORD_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic [WORD_W-1:0]     mem_rd_data,
    input  logic                  acc_wr_en,
    input  logic                  acc_wr_hi,
    input  logic [WORD_W-1:0]     acc_wr_data,
    output logic [WORD_W-1:0]     acc_lo,
    output logic [WORD_W-1:0]     acc_hi,
    output logic                  base_wr_en,
    output logic [WORD_W-1:0]     base_wr_data,
    output logic                  done,
    output logic                  reserved_err,
    output logic                  align_err
);
    mac_state_e                      state_q;
    mac_req_t                        live_req, held_req, use_req;
    logic [WORD_W-1:0]               held_rt, held_addr, ld_addr;
    logic [NUM_MREG-1:0][WORD_W-1:0] mreg_q;
    acc_t                            acc_q;
    logic [WORD_W-1:0]               new_lo, new_hi;
    logic                            waiting, rsv, misaligned, go_load, load_back;

    logic [1:0]                      from_m, pick_2nd, take_up;
    logic [1:0][WORD_W-1:0]          reg_word, opnd;

    assign live_req = '{
        cls:     mac_class_e'(req_class),
        src_a_m: req_src_a_m,
        src_b_m: req_src_b_m,
        hi_a:    req_hi_a,
        hi_b:    req_hi_b,
        sel_x:   req_sel_x,
        sel_y:   req_sel_y,
        do_mul:  req_mul,
        do_load: req_load,
        dec:     req_dec,
        ld_dst:  req_ld_dst
    };

    assign waiting   = (state_q == ST_WAIT);
    assign use_req   = waiting ? held_req : live_req;
    assign load_back = waiting && mem_rd_valid;

    // Request legality and address formation
    always_comb begin
        ld_addr = live_req.dec ? rs_data - WORD_W'(ADDR_STEP)
                               : rs_data + WORD_W'(ADDR_STEP);
        rsv = (live_req.do_load && live_req.do_mul && live_req.cls != CLS_MULA)
            || (live_req.do_mul && live_req.cls == CLS_UMUL
                && (live_req.src_a_m || live_req.src_b_m || live_req.do_load))
            || (!live_req.do_mul && !live_req.do_load);
        misaligned = live_req.do_load && (ld_addr[ALIGN_W-1:0] != '0);
        go_load    = live_req.do_load && !rsv && !misaligned;
    end

    // Operand routing: a load forces the first operand onto the registers
    always_comb begin
        from_m[0]   = use_req.src_a_m || use_req.do_load;
        from_m[1]   = use_req.src_b_m;
        pick_2nd[0] = use_req.sel_x;
        pick_2nd[1] = use_req.sel_y;
        take_up[0]  = use_req.hi_a;
        take_up[1]  = use_req.hi_b;
        reg_word[0] = rs_data;
        reg_word[1] = waiting ? held_rt : rt_data;
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
        halfmac_operand u_opnd (
            .reg_word    (reg_word[gi]),
            .m_first     (mreg_q[2*gi]),
            .m_second    (mreg_q[2*gi+1]),
            .from_mreg   (from_m[gi]),
            .pick_second (pick_2nd[gi]),
            .take_upper  (take_up[gi]),
            .is_unsigned (use_req.cls == CLS_UMUL),
            .value       (opnd[gi])
        );
    end

    halfmac_accum u_accum (
        .cls    (use_req.cls),
        .op_a   (opnd[0]),
        .op_b   (opnd[1]),
        .lo_in  (acc_q.lo),
        .top_in (acc_q.hi[TOP_W-1:0]),
        .lo_out (new_lo),
        .hi_out (new_hi)
    );

    halfmac_mregs u_mregs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (load_back),
        .wr_idx  (held_req.ld_dst),
        .wr_data (mem_rd_data),
        .regs    (mreg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            held_req     <= '0;
            held_rt      <= '0;
            held_addr    <= '0;
            acc_q        <= '0;
            done         <= 1'b0;
            reserved_err <= 1'b0;
            align_err    <= 1'b0;
            base_wr_en   <= 1'b0;
        end else begin
            done         <= 1'b0;
            reserved_err <= 1'b0;
            align_err    <= 1'b0;
            base_wr_en   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        done         <= !go_load;
                        reserved_err <= rsv;
                        align_err    <= !rsv && misaligned;
                        if (go_load) begin
                            state_q   <= ST_WAIT;
                            held_req  <= live_req;
                            held_rt   <= rt_data;
                            held_addr <= ld_addr;
                        end else if (!rsv && !misaligned && live_req.do_mul) begin
                            acc_q <= '{hi: new_hi, lo: new_lo};
                        end
                    end else if (acc_wr_en) begin
                        if (acc_wr_hi) acc_q.hi <= top_sext(acc_wr_data[TOP_W-1:0]);
                        else           acc_q.lo <= acc_wr_data;
                    end
                end
                ST_WAIT: begin
                    if (mem_rd_valid) begin
                        state_q    <= ST_IDLE;
                        done       <= 1'b1;
                        base_wr_en <= 1'b1;
                        if (held_req.do_mul) acc_q <= '{hi: new_hi, lo: new_lo};
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready    = !waiting;
    assign mem_rd_req   = waiting;
    assign mem_rd_addr  = held_addr;
    assign base_wr_data = held_addr;
    assign acc_lo       = acc_q.lo;
    assign acc_hi       = acc_q.hi;
endmodule

// File: rtl/halfmac_unit_chk.sv
module halfmac_unit_chk
    import halfmac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              mem_rd_req,
    input logic [WORD_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic [WORD_W-1:0] acc_lo,
    input logic [WORD_W-1:0] acc_hi,
    input logic              base_wr_en,
    input logic              done,
    input logic              reserved_err,
    input logic              align_err
);
    assert_top_sext_R4: assert property (@(posedge clk) disable iff (rst)
        acc_hi[WORD_W-1:TOP_W] == {(WORD_W-TOP_W){acc_hi[TOP_W-1]}});

    assert_rd_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> mem_rd_addr[ALIGN_W-1:0] == '0);

    assert_misalign_done_R9: assert property (@(posedge clk) disable iff (rst)
        align_err |-> done && !base_wr_en && !reserved_err);

    assert_reserved_done_R8: assert property (@(posedge clk) disable iff (rst)
        reserved_err |-> done && !base_wr_en);

    assert_err_keeps_acc_R8: assert property (@(posedge clk) disable iff (rst)
        (done && (reserved_err || align_err)) |->
            (acc_lo == $past(acc_lo) && acc_hi == $past(acc_hi)));

    assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    assert_busy_R11: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready);

    assert_base_done_R6: assert property (@(posedge clk) disable iff (rst)
        base_wr_en |-> done);
endmodule

bind halfmac_unit halfmac_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_ready    (req_ready),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .acc_lo       (acc_lo),
    .acc_hi       (acc_hi),
    .base_wr_en   (base_wr_en),
    .done         (done),
    .reserved_err (reserved_err),
    .align_err    (align_err)
);

// File: tb/tb_halfmac_unit.sv
module tb_halfmac_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready;
    logic [1:0]  req_class;
    logic        req_src_a_m, req_src_b_m, req_hi_a, req_hi_b, req_sel_x, req_sel_y;
    logic        req_mul, req_load, req_dec;
    logic [1:0]  req_ld_dst;
    logic [31:0] rs_data, rt_data;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_data;
    logic        acc_wr_en, acc_wr_hi;
    logic [31:0] acc_wr_data;
    logic [31:0] acc_lo, acc_hi;
    logic        base_wr_en;
    logic [31:0] base_wr_data;
    logic        done, reserved_err, align_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    halfmac_unit dut (.*);

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic clear_inputs();
        req_valid = 0; req_class = 0; req_src_a_m = 0; req_src_b_m = 0;
        req_hi_a = 0; req_hi_b = 0; req_sel_x = 0; req_sel_y = 0;
        req_mul = 0; req_load = 0; req_dec = 0; req_ld_dst = 0;
        rs_data = 0; rt_data = 0; mem_rd_valid = 0; mem_rd_data = 0;
        acc_wr_en = 0; acc_wr_hi = 0; acc_wr_data = 0;
    endtask

    // Accept one request without a load; leaves the cycle after the accept edge
    task automatic issue(input logic [1:0] cls, input logic am, input logic bm,
                         input logic ha, input logic hb, input logic sx, input logic sy,
                         input logic mul, input logic ld, input logic [31:0] rs,
                         input logic [31:0] rt);
        @(negedge clk);
        req_valid = 1; req_class = cls; req_src_a_m = am; req_src_b_m = bm;
        req_hi_a = ha; req_hi_b = hb; req_sel_x = sx; req_sel_y = sy;
        req_mul = mul; req_load = ld; rs_data = rs; rt_data = rt;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_acc(input string tag, input logic [31:0] lo, input logic [31:0] hi);
        chk({tag, " acc_lo"}, acc_lo, lo);
        chk({tag, " acc_hi"}, acc_hi, hi);
    endtask

    task automatic direct_write(input logic hi, input logic [31:0] d);
        @(negedge clk);
        acc_wr_en = 1; acc_wr_hi = hi; acc_wr_data = d;
        @(negedge clk);
        acc_wr_en = 0;
    endtask

    // Load with optional multiply-add; memory answers after lat idle cycles
    task automatic load_op(input string tag, input logic mul, input logic dec,
                           input logic [1:0] dst, input logic bm, input logic ha,
                           input logic hb, input logic sx, input logic sy,
                           input logic [31:0] rs, input logic [31:0] rt,
                           input logic [31:0] word, input int lat,
                           input logic [31:0] exp_addr);
        @(negedge clk);
        req_valid = 1; req_class = 2'd2; req_mul = mul; req_load = 1; req_dec = dec;
        req_ld_dst = dst; req_src_a_m = 0; req_src_b_m = bm; req_hi_a = ha; req_hi_b = hb;
        req_sel_x = sx; req_sel_y = sy; rs_data = rs; rt_data = rt;
        @(negedge clk);
        req_valid = 0; req_load = 0; rs_data = 32'hDEAD_0000; rt_data = 32'h0;
        chk({tag, " R11 rd_req"}, {31'd0, mem_rd_req}, 32'd1);
        chk({tag, " R6 rd_addr"}, mem_rd_addr, exp_addr);
        chk({tag, " R11 ready low"}, {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < lat; i++) @(negedge clk);
        chk({tag, " R11 no early done"}, {31'd0, done}, 32'd0);
        mem_rd_valid = 1; mem_rd_data = word;
        @(negedge clk);
        mem_rd_valid = 0;
        chk({tag, " R11 done"}, {31'd0, done}, 32'd1);
        chk({tag, " R6 base_wr_en"}, {31'd0, base_wr_en}, 32'd1);
        chk({tag, " R6 base"}, base_wr_data, exp_addr);
    endtask

    task automatic t_reset();
        expect_acc("reset R11", 32'h0, 32'h0);
        chk("reset R11 done", {31'd0, done}, 32'd0);
        chk("reset R11 ready", {31'd0, req_ready}, 32'd1);
        chk("reset R11 rd_req", {31'd0, mem_rd_req}, 32'd0);
    endtask

    task automatic t_umul();
        issue(2'd0, 0, 0, 1, 0, 0, 0, 1, 0, 32'hFFFF_0000, 32'h0000_FFFF);
        chk("R11 umul done", {31'd0, done}, 32'd1);
        expect_acc("R1 R2 umul", 32'hFFFE_0001, 32'h0);
    endtask

    task automatic t_mul();
        issue(2'd1, 0, 0, 1, 0, 0, 0, 1, 0, 32'h8000_0003, 32'h0000_FFFF);
        expect_acc("R1 R3 mul pos", 32'h0000_8000, 32'h0);
        issue(2'd1, 0, 0, 0, 1, 0, 0, 1, 0, 32'h0000_FFFE, 32'h0003_0000);
        expect_acc("R3 mul neg", 32'hFFFF_FFFA, 32'hFFFF_FFFF);
    endtask

    task automatic t_direct();
        direct_write(0, 32'hFFFF_FFFF);
        direct_write(1, 32'h1234_5680);
        expect_acc("R10 hi neg", 32'hFFFF_FFFF, 32'hFFFF_FF80);
        direct_write(1, 32'h0000_017F);
        expect_acc("R10 hi pos", 32'hFFFF_FFFF, 32'h0000_007F);
    endtask

    task automatic t_mula_muls();
        issue(2'd2, 0, 0, 0, 0, 0, 0, 1, 0, 32'h1, 32'h1);
        expect_acc("R4 mula carry", 32'h0, 32'hFFFF_FF80);
        issue(2'd3, 0, 0, 0, 0, 0, 0, 1, 0, 32'h1, 32'h1);
        expect_acc("R4 muls borrow", 32'hFFFF_FFFF, 32'h0000_007F);
    endtask

    task automatic t_loads();
        load_op("ld m0 inc", 0, 0, 2'd0, 0, 0, 0, 0, 0, 32'h200, 0, 32'h0007_0002, 3, 32'h204);
        expect_acc("R7 load only", 32'hFFFF_FFFF, 32'h0000_007F);
        load_op("ld m2 dec", 0, 1, 2'd2, 0, 0, 0, 0, 0, 32'h300, 0, 32'hFFFE_0004, 0, 32'h2FC);
        load_op("ld m1", 0, 0, 2'd1, 0, 0, 0, 0, 0, 32'h10, 0, 32'h0000_0009, 1, 32'h14);
        load_op("ld m3", 0, 0, 2'd3, 0, 0, 0, 0, 0, 32'h20, 0, 32'h0000_0005, 2, 32'h24);
        issue(2'd1, 1, 1, 1, 0, 0, 0, 1, 0, 32'h0, 32'h0);
        expect_acc("R5 m0 hi * m2 lo", 32'd28, 32'h0);
        issue(2'd1, 1, 1, 0, 1, 0, 0, 1, 0, 32'h0, 32'h0);
        expect_acc("R5 m0 lo * m2 hi", 32'hFFFF_FFFC, 32'hFFFF_FFFF);
        issue(2'd1, 1, 1, 0, 0, 1, 1, 1, 0, 32'h0, 32'h0);
        expect_acc("R5 m1 * m3", 32'd45, 32'h0);
        issue(2'd1, 1, 1, 0, 1, 0, 0, 1, 0, 32'h0, 32'h0);
        expect_acc("R5 restore -4", 32'hFFFF_FFFC, 32'hFFFF_FFFF);
    endtask

    task automatic t_load_mula();
        // old m0 upper half 7 times rt lower half 3, added to -4 gives 17
        load_op("ld+mula", 1, 1, 2'd0, 0, 1, 0, 0, 0, 32'h100, 32'h3, 32'h0001_0001, 2, 32'hFC);
        expect_acc("R6 mula with load", 32'd17, 32'h0);
        issue(2'd1, 1, 1, 1, 0, 0, 0, 1, 0, 32'h0, 32'h0);
        expect_acc("R6 m0 reloaded", 32'd4, 32'h0);
    endtask

    task automatic t_reserved();
        issue(2'd0, 1, 0, 0, 0, 0, 0, 1, 0, 32'h5, 32'h5);
        chk("R8 umul mreg flag", {31'd0, reserved_err}, 32'd1);
        chk("R8 umul mreg done", {31'd0, done}, 32'd1);
        chk("R8 umul mreg no rd", {31'd0, mem_rd_req}, 32'd0);
        expect_acc("R8 umul mreg acc", 32'd4, 32'h0);
        issue(2'd1, 0, 0, 0, 0, 0, 0, 1, 1, 32'h400, 32'h5);
        chk("R8 load+mul flag", {31'd0, reserved_err}, 32'd1);
        chk("R8 load+mul no rd", {31'd0, mem_rd_req}, 32'd0);
        chk("R8 load+mul no base", {31'd0, base_wr_en}, 32'd0);
        issue(2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 32'h1, 32'h1);
        chk("R8 empty flag", {31'd0, reserved_err}, 32'd1);
        expect_acc("R8 acc kept", 32'd4, 32'h0);
    endtask

    task automatic t_align();
        issue(2'd2, 0, 0, 0, 0, 0, 0, 0, 1, 32'h101, 32'h0);
        chk("R9 align flag", {31'd0, align_err}, 32'd1);
        chk("R9 align done", {31'd0, done}, 32'd1);
        chk("R9 no rd", {31'd0, mem_rd_req}, 32'd0);
        chk("R9 no base", {31'd0, base_wr_en}, 32'd0);
        chk("R9 ready", {31'd0, req_ready}, 32'd1);
        expect_acc("R9 acc kept", 32'd4, 32'h0);
    endtask

    task automatic t_write_collision();
        @(negedge clk);
        acc_wr_en = 1; acc_wr_hi = 1; acc_wr_data = 32'h55;
        req_valid = 1; req_class = 2'd1; req_src_a_m = 0; req_src_b_m = 0;
        req_hi_a = 0; req_hi_b = 0; req_mul = 1; req_load = 0;
        rs_data = 32'h2; rt_data = 32'h3;
        @(negedge clk);
        req_valid = 0; acc_wr_en = 0;
        expect_acc("R10 write ignored on accept", 32'd6, 32'h0);
    endtask

    initial begin
        clear_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_umul();
        t_mul();
        t_direct();
        t_mula_muls();
        t_loads();
        t_load_mula();
        t_reserved();
        t_align();
        t_write_collision();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule